// File: doc/BRIEF.md
# Microcontroller Interrupt Controller

This block gathers interrupt events for a small 8-bit processor core and turns them into vector fetch requests. Eight sources feed it. Seven are single-cycle event pulses from on-chip units: a timer overflow, three timer matches, SPI receive, SPI transmit and one auxiliary peripheral. The eighth is an asynchronous external pin, which the block synchronizes and edge-detects itself. Each event latches a sticky flag. A per-source enable register masks the flags, and a global enable gates the masked result before the fetch unit is asked to jump.

The core drives strobes that set or clear the global enable, a return-from-service strobe that sets it again, and a software-interrupt strobe. When a hardware interrupt is taken, the block clears the global enable on its own and raises a request for the hardware service vector. A software interrupt asks for a separate vector. Either request is held until the core acknowledges it. A wake output tells the sleep logic that the external pin has fired while the core is asleep.

Top module: `irq_ctrl`

## Requirements
- R1: A pulse on `evt_i[k]` sets flag k at the next clock edge, whatever the state of enable k. The flag positions are: timer0 overflow bit 0, external pin bit 1, timer3 match bit 2, timer1 match bit 3, timer2 match bit 4, SPI receive bit 5, SPI transmit bit 6, auxiliary bit 7. `evt_i[1]` is ignored, because flag 1 comes only from the pin.
- R2: `flag_rd_o` always equals flags AND enables. `en_rd_o` shows the enable register. `en_wr_i` loads `en_wdata_i` at the next edge whatever the global enable is.
- R3: `flag_clr_i` clears every flag whose bit is 1 in `flag_clr_mask_i` at the next edge. If an event for a bit arrives in the same cycle as its clear, the flag ends up set.
- R4: A timer1 match event (`evt_i[3]`) also sets the status bit `t1_stat_o`, and `t1_stat_clr_i` clears it. While `t1_stat_o` is 1, a clear aimed at flag bit 3 has no effect.
- R5: `ext_pin_i` passes through a two-flop synchronizer. With `edge_sel_i`=1 only rising pin edges set flag 1; with 0 only falling edges do. The flag becomes visible after the third rising clock edge following the pin change.
- R6: The global enable `gie_o` is 0 after reset. `gie_set_i` or `reti_i` set it, and `gie_clr_i` clears it. If a set and a clear arrive in the same cycle, the clear wins.
- R7: When `gie_o` is 1, at least one enabled flag is set and no request is outstanding, the next edge raises `vec_req_o` with `vec_addr_o`=1 and clears `gie_o`.
- R8: `swi_i` raises `vec_req_o` with `vec_addr_o`=2 at the next edge and leaves `gie_o` unchanged. The strobe is dropped if a request is already outstanding, or if a hardware interrupt is taken in the same cycle.
- R9: `vec_req_o` and `vec_addr_o` hold steady until `vec_ack_i` is seen. The request drops at the edge that samples the acknowledge.
- R10: `wake_o` is 1 while `sleep_i` is 1 and the pin flag and pin enable are both set, whatever `gie_o` is. No other source drives `wake_o`.
- R11: After reset, flags, enables, `t1_stat_o`, `gie_o`, `vec_req_o` and `wake_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 8 | Event pulses, one per flag position (bit 1 unused) |
| ext_pin_i | input | 1 | Asynchronous external interrupt pin |
| edge_sel_i | input | 1 | Pin edge select: 1 = rising, 0 = falling |
| en_wr_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 8 | Enable register write data |
| flag_clr_i | input | 1 | Flag clear strobe |
| flag_clr_mask_i | input | 8 | Flags to clear (1 = clear) |
| t1_stat_clr_i | input | 1 | Clears the timer1 status bit |
| gie_set_i | input | 1 | Global enable set strobe |
| gie_clr_i | input | 1 | Global enable clear strobe |
| reti_i | input | 1 | Return-from-service strobe (sets global enable) |
| swi_i | input | 1 | Software interrupt strobe |
| vec_ack_i | input | 1 | Core acknowledge of the vector request |
| sleep_i | input | 1 | Core is sleeping |
| flag_rd_o | output | 8 | Flags ANDed with enables |
| en_rd_o | output | 8 | Enable register |
| t1_stat_o | output | 1 | Timer1 status bit |
| gie_o | output | 1 | Global enable |
| vec_req_o | output | 1 | Vector fetch request |
| vec_addr_o | output | 8 | Requested vector address |
| wake_o | output | 1 | Wake-from-sleep indication |

## Verification
Register writes, flag sets and clears, status changes and global enable updates all appear one edge after the strobe. A vector request appears one edge after its flag is visible, so two edges after the event pulse. The pin flag appears only after the third edge following a pin change, and an acknowledge drops the request at the edge that samples it. The bench drives every input on the falling clock edge and samples each output at the falling edge that follows the edge where its result is due. For the pin, it also checks one edge early that the flag is not yet set.

// File: rtl/irq_ctrl_pkg.sv
`timescale 1ns/1ps
// irq_ctrl_pkg: shared constants and types for the interrupt controller.
// Assumes exactly eight sources; flag positions are fixed here so that
// software and the controller agree on them.
package irq_ctrl_pkg;
    localparam int NSRC    = 8;
    localparam int IDX_T0  = 0;  // timer0 overflow
    localparam int IDX_PIN = 1;  // external pin
    localparam int IDX_T3  = 2;  // timer3 match
    localparam int IDX_T1  = 3;  // timer1 match
    localparam int IDX_T2  = 4;  // timer2 match
    localparam int IDX_SRX = 5;  // SPI receive
    localparam int IDX_STX = 6;  // SPI transmit
    localparam int IDX_AUX = 7;  // auxiliary peripheral

    typedef logic [NSRC-1:0] src_vec_t;

    // Which kind of vector the outstanding request refers to.
    typedef enum logic [1:0] {
        VK_NONE = 2'd0,
        VK_HW   = 2'd1,
        VK_SW   = 2'd2
    } vec_kind_e;
endpackage

// File: rtl/irq_pin_edge.sv
`timescale 1ns/1ps
// irq_pin_edge: synchronizes an asynchronous pin through STAGES flops and
// reports a one-cycle pulse on the selected edge.
// Assumes STAGES >= 2 and that edge_sel changes only while the pin is quiet.
module irq_pin_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic rise_sel_i,
    output logic edge_o
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;
    logic              rise, fall;

    // Synchronizer chain plus a history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_i};
            last_q <= sync_q[STAGES-1];
        end
    end

    // Edge classification on the synchronized level.
    always_comb begin
        rise   = sync_q[STAGES-1] & ~last_q;
        fall   = ~sync_q[STAGES-1] & last_q;
        edge_o = rise_sel_i ? rise : fall;
    end
endmodule

// File: rtl/irq_flag_bank.sv
`timescale 1ns/1ps
// irq_flag_bank: sticky event flags, the enable register and the timer1
// companion status bit. A set in the same cycle as a clear wins; a clear
// of the timer1 flag is blocked while its status bit is high.
// Assumes set_i carries single-cycle event pulses already in flag order.
module irq_flag_bank
    import irq_ctrl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t set_i,
    input  logic     en_wr_i,
    input  src_vec_t en_wdata_i,
    input  logic     clr_i,
    input  src_vec_t clr_mask_i,
    input  logic     stat_clr_i,
    output src_vec_t flag_o,
    output src_vec_t en_o,
    output logic     stat_o
);
    src_vec_t flag_q, en_q, clr_eff;
    logic     stat_q;

    // Per-bit clear qualification; the timer1 bit is gated by its status.
    for (genvar i = 0; i < NSRC; i++) begin : g_clr
        if (i == IDX_T1) begin : g_guarded
            assign clr_eff[i] = clr_i & clr_mask_i[i] & ~stat_q;
        end else begin : g_plain
            assign clr_eff[i] = clr_i & clr_mask_i[i];
        end
    end

    // Flag register: clear selected bits, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~clr_eff) | set_i;
    end

    // Enable register: loaded whenever written.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= '0;
        else if (en_wr_i) en_q <= en_wdata_i;
    end

    // Timer1 status bit: set by a timer1 event, which wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)               stat_q <= 1'b0;
        else if (set_i[IDX_T1])   stat_q <= 1'b1;
        else if (stat_clr_i)      stat_q <= 1'b0;
    end

    assign flag_o = flag_q;
    assign en_o   = en_q;
    assign stat_o = stat_q;

    AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((flag_q & $past(set_i)) == $past(set_i)));  // R1
    AST_T1_CLEAR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q && flag_q[IDX_T1]) |=> flag_q[IDX_T1]);  // R4
endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
// irq_arbiter: keeps the global enable, takes hardware interrupts when
// enabled work is pending and accepts software interrupts, holding one
// request at a time until the core acknowledges it.
// Assumes all strobes are single-cycle and synchronous to clk.
module irq_arbiter
    import irq_ctrl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pending_i,
    input  logic      gie_set_i,
    input  logic      gie_clr_i,
    input  logic      reti_i,
    input  logic      swi_i,
    input  logic      ack_i,
    output logic      gie_o,
    output logic      req_o,
    output vec_kind_e kind_o
);
    logic      gie_q, req_q;
    vec_kind_e kind_q;
    logic      take_hw, take_sw;

    // Decide which request, if any, starts this cycle; hardware wins.
    always_comb begin
        take_hw = gie_q & pending_i & ~req_q;
        take_sw = swi_i & ~req_q & ~take_hw;
    end

    // Request register: raised by a take, dropped by the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            kind_q <= VK_NONE;
        end else if (req_q && ack_i) begin
            req_q  <= 1'b0;
            kind_q <= VK_NONE;
        end else if (take_hw) begin
            req_q  <= 1'b1;
            kind_q <= VK_HW;
        end else if (take_sw) begin
            req_q  <= 1'b1;
            kind_q <= VK_SW;
        end
    end

    // Global enable: a take or a disable clears it, ahead of any set.
    always_ff @(posedge clk) begin
        if (!rst_n)                      gie_q <= 1'b0;
        else if (take_hw || gie_clr_i)   gie_q <= 1'b0;
        else if (gie_set_i || reti_i)    gie_q <= 1'b1;
    end

    assign gie_o  = gie_q;
    assign req_o  = req_q;
    assign kind_o = kind_q;

    AST_TAKE_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_q) && kind_q == VK_HW) |-> !gie_q);  // R7
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && !ack_i) |=> (req_q && $stable(kind_q)));  // R9
    AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && ack_i) |=> !req_q);  // R9
endmodule

// File: rtl/irq_ctrl.sv
`timescale 1ns/1ps
// irq_ctrl: interrupt controller top. Routes the synchronized pin edge into
// the flag bank, masks flags with enables for readback and for the
// arbiter, maps request kinds to vector addresses and produces wake.
// Assumes the core samples vec_addr_o while vec_req_o is high.
module irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int          SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] HW_VEC = 'd1,
    parameter logic [ADDR_W-1:0] SW_VEC = 'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   evt_i,
    input  logic              ext_pin_i,
    input  logic              edge_sel_i,
    input  logic              en_wr_i,
    input  logic [NSRC-1:0]   en_wdata_i,
    input  logic              flag_clr_i,
    input  logic [NSRC-1:0]   flag_clr_mask_i,
    input  logic              t1_stat_clr_i,
    input  logic              gie_set_i,
    input  logic              gie_clr_i,
    input  logic              reti_i,
    input  logic              swi_i,
    input  logic              vec_ack_i,
    input  logic              sleep_i,
    output logic [NSRC-1:0]   flag_rd_o,
    output logic [NSRC-1:0]   en_rd_o,
    output logic              t1_stat_o,
    output logic              gie_o,
    output logic              vec_req_o,
    output logic [ADDR_W-1:0] vec_addr_o,
    output logic              wake_o
);
    logic      pin_edge;
    src_vec_t  set_vec, flags, enables, active;
    vec_kind_e kind;
    logic      unused_pin_evt;

    assign unused_pin_evt = evt_i[IDX_PIN];

    irq_pin_edge #(.STAGES(SYNC_STAGES)) u_pin (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (ext_pin_i),
        .rise_sel_i(edge_sel_i),
        .edge_o    (pin_edge)
    );

    // Source routing: the pin position takes the synchronized edge.
    for (genvar i = 0; i < NSRC; i++) begin : g_route
        if (i == IDX_PIN) begin : g_pin
            assign set_vec[i] = pin_edge;
        end else begin : g_evt
            assign set_vec[i] = evt_i[i];
        end
    end

    irq_flag_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (set_vec),
        .en_wr_i   (en_wr_i),
        .en_wdata_i(en_wdata_i),
        .clr_i     (flag_clr_i),
        .clr_mask_i(flag_clr_mask_i),
        .stat_clr_i(t1_stat_clr_i),
        .flag_o    (flags),
        .en_o      (enables),
        .stat_o    (t1_stat_o)
    );

    // Masked view shared by readback, arbitration and wake.
    assign active = flags & enables;

    irq_arbiter u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .pending_i(|active),
        .gie_set_i(gie_set_i),
        .gie_clr_i(gie_clr_i),
        .reti_i   (reti_i),
        .swi_i    (swi_i),
        .ack_i    (vec_ack_i),
        .gie_o    (gie_o),
        .req_o    (vec_req_o),
        .kind_o   (kind)
    );

    // Vector address selection from the outstanding request kind.
    always_comb begin
        case (kind)
            VK_HW:   vec_addr_o = HW_VEC;
            VK_SW:   vec_addr_o = SW_VEC;
            default: vec_addr_o = '0;
        endcase
    end

    assign flag_rd_o = active;
    assign en_rd_o   = enables;
    assign wake_o    = sleep_i & active[IDX_PIN];

    AST_PIN_EDGE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        pin_edge |=> flags[IDX_PIN]);  // R5
endmodule

// File: tb/tb_irq_ctrl.sv
`timescale 1ns/1ps
module tb_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] evt_i = '0, en_wdata_i = '0, flag_clr_mask_i = '0;
    logic       ext_pin_i = 0, edge_sel_i = 1, en_wr_i = 0, flag_clr_i = 0;
    logic       t1_stat_clr_i = 0, gie_set_i = 0, gie_clr_i = 0, reti_i = 0;
    logic       swi_i = 0, vec_ack_i = 0, sleep_i = 0;
    logic [7:0] flag_rd_o, en_rd_o, vec_addr_o;
    logic       t1_stat_o, gie_o, vec_req_o, wake_o;
    int         n_chk = 0, n_fail = 0, cyc = 0;

    always #5 clk = ~clk;

    irq_ctrl dut (.*);

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_evt(input logic [7:0] m);
        evt_i = m; tick(); evt_i = '0;
    endtask
    task automatic wr_en(input logic [7:0] v);
        en_wr_i = 1; en_wdata_i = v; tick(); en_wr_i = 0;
    endtask
    task automatic clr(input logic [7:0] m);
        flag_clr_i = 1; flag_clr_mask_i = m; tick(); flag_clr_i = 0; flag_clr_mask_i = '0;
    endtask

    task automatic t_reset();
        check("R11 flags", flag_rd_o, 0);
        check("R11 enables", en_rd_o, 0);
        check("R11 t1 status", t1_stat_o, 0);
        check("R11 gie", gie_o, 0);
        check("R11 vec_req", vec_req_o, 0);
        check("R11 wake", wake_o, 0);
    endtask

    task automatic t_flags();
        pulse_evt(8'hFF);
        check("R2 masked by zero enables", flag_rd_o, 8'h00);
        wr_en(8'hFF);
        check("R2 enable readback", en_rd_o, 8'hFF);
        check("R1 all events latched, bit1 ignored", flag_rd_o, 8'hFD);
        check("R7 no request while gie off", vec_req_o, 0);
        check("R4 status set by timer1", t1_stat_o, 1);
        clr(8'hFF);
        check("R4 timer1 flag clear blocked", flag_rd_o, 8'h08);
        t1_stat_clr_i = 1; tick(); t1_stat_clr_i = 0;
        check("R4 status cleared", t1_stat_o, 0);
        clr(8'h08);
        check("R4 timer1 flag clears after status", flag_rd_o, 8'h00);
    endtask

    task automatic t_race();
        evt_i = 8'h20; flag_clr_i = 1; flag_clr_mask_i = 8'h20; tick();
        evt_i = '0; flag_clr_i = 0; flag_clr_mask_i = '0;
        check("R3 event beats clear", flag_rd_o, 8'h20);
        clr(8'h20);
        check("R3 clear", flag_rd_o, 8'h00);
    endtask

    task automatic t_pin();
        edge_sel_i = 1; ext_pin_i = 1;
        tick(); tick();
        check("R5 not before third edge", flag_rd_o, 8'h00);
        tick();
        check("R5 rising edge flag", flag_rd_o, 8'h02);
        clr(8'h02);
        ext_pin_i = 0; repeat (4) tick();
        check("R5 falling ignored when rising selected", flag_rd_o, 8'h00);
        edge_sel_i = 0; ext_pin_i = 1; repeat (4) tick();
        check("R5 rising ignored when falling selected", flag_rd_o, 8'h00);
        ext_pin_i = 0; repeat (3) tick();
        check("R5 falling edge flag", flag_rd_o, 8'h02);
        clr(8'h02);
    endtask

    task automatic t_wake();
        wr_en(8'h02); sleep_i = 1;
        ext_pin_i = 1; repeat (3) tick();
        ext_pin_i = 0; repeat (3) tick();
        check("R10 wake with gie off", wake_o, 1);
        check("R10 no vector with gie off", vec_req_o, 0);
        wr_en(8'h00);
        check("R10 no wake when pin disabled", wake_o, 0);
        wr_en(8'h02); clr(8'h02);
        check("R10 no wake without flag", wake_o, 0);
        wr_en(8'hFF); pulse_evt(8'h01);
        check("R10 other source does not wake", wake_o, 0);
        clr(8'h01); sleep_i = 0;
    endtask

    task automatic t_gie();
        gie_set_i = 1; tick(); gie_set_i = 0;
        check("R6 set strobe", gie_o, 1);
        gie_clr_i = 1; tick(); gie_clr_i = 0;
        check("R6 clear strobe", gie_o, 0);
        reti_i = 1; tick(); reti_i = 0;
        check("R6 return sets", gie_o, 1);
        gie_set_i = 1; gie_clr_i = 1; tick(); gie_set_i = 0; gie_clr_i = 0;
        check("R6 clear wins", gie_o, 0);
        check("R7 idle without flags", vec_req_o, 0);
    endtask

    task automatic t_hw();
        wr_en(8'h10);
        gie_set_i = 1; tick(); gie_set_i = 0;
        pulse_evt(8'h10);
        check("R7 flag visible first", flag_rd_o, 8'h10);
        check("R7 request one edge later", vec_req_o, 0);
        tick();
        check("R7 request raised", vec_req_o, 1);
        check("R7 hardware vector", vec_addr_o, 8'd1);
        check("R7 gie cleared", gie_o, 0);
        repeat (3) tick();
        check("R9 held without ack", vec_req_o, 1);
        swi_i = 1; tick(); swi_i = 0;
        check("R8 swi ignored while outstanding", vec_addr_o, 8'd1);
        vec_ack_i = 1; tick(); vec_ack_i = 0;
        check("R9 ack drops request", vec_req_o, 0);
        tick();
        check("R8 dropped swi not replayed", vec_req_o, 0);
        clr(8'h10);
    endtask

    task automatic t_swi();
        gie_set_i = 1; tick(); gie_set_i = 0;
        swi_i = 1; tick(); swi_i = 0;
        check("R8 software request", vec_req_o, 1);
        check("R8 software vector", vec_addr_o, 8'd2);
        check("R8 gie unchanged", gie_o, 1);
        vec_ack_i = 1; tick(); vec_ack_i = 0;
        check("R9 ack drops software request", vec_req_o, 0);
        wr_en(8'h00); pulse_evt(8'h80);
        wr_en(8'h80);
        swi_i = 1; tick(); swi_i = 0;
        check("R8 hardware wins same cycle", vec_addr_o, 8'd1);
        check("R8 gie cleared by hardware take", gie_o, 0);
        vec_ack_i = 1; tick(); vec_ack_i = 0; tick();
        check("R8 simultaneous swi dropped", vec_req_o, 0);
        clr(8'h80);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk); cyc++;
            if (cyc > 20000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual %0d expected below 20000", cyc);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_flags();
        t_race();
        t_pin();
        t_wake();
        t_gie();
        t_hw();
        t_swi();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule